// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

The translator turns a segmented logical address, made of a segment register choice and an effective offset, into a linear address. It holds six segment registers. Each one keeps a visible 16-bit selector and a cached copy of its descriptor: base, limit, and for the code register a long-mode flag. Descriptors are not fetched from memory by this block. They arrive on a load port together with the selector. Each load is checked for legality and is refused with a general-protection indication when it is illegal. A refused load leaves the register as it was.

Address translation is combinational from the access request to the linear address and the fault code. A mode input picks real-address, protected or long operation. In long operation, the long flag of the cached code descriptor decides between full 64-bit addressing and 32-bit compatibility addressing. The base and limit rules change with the effective mode and with the chosen register. Limit violations through the stack register are reported as stack faults. Paging is left to a later stage.

Top module: `seg_translator`

## Requirements
- R1: After synchronous reset the code register holds selector 0xF000, the effective mode is real (eff_mode = 0) and the privilege level is 0, so a code access at offset 0xFFF0 yields linear address 0x000FFFF0.
- R2: In real mode (mode = 0 or 3) the linear address is (selector × 16) + offset[15:0]; offset bits above bit 15 are ignored, no fault is raised, and loads never fault.
- R3: In protected operation (mode = 1, or mode = 2 with the code long flag clear) the linear address is (base[31:0] + offset[31:0]) modulo 2^32; offset bits above 31 are ignored.
- R4: In protected operation an offset[31:0] greater than the cached limit raises fault code 1 (general protection) on any register but the stack register, and lin_valid is low.
- R5: In protected operation a limit violation through the stack register (index 1) raises fault code 2 (stack fault) instead of code 1.
- R6: In 64-bit operation (mode = 2 and code long flag set) the base of the code, stack, DS and ES registers counts as zero, FS and GS add their full 64-bit base, no limit check is made, and the 64-bit sum is output.
- R7: A selector is null when bits [15:2] are zero. Outside real mode, a null selector load into the code register faults. A null load into any data register is accepted. A reference through a null data register faults with code 1 in protected operation and does not fault in 64-bit operation.
- R8: Outside real mode a code register load needs ld_code = 1 and a non-null data register load needs ld_code = 0; a mismatch raises ld_fault and the register keeps its previous contents.
- R9: cpl equals bits [1:0] of the code selector; in mode 2, eff_mode is 2 when the loaded code descriptor has the long flag set and 1 otherwise.
- R10: Register indices are 0 code, 1 stack, 2 DS, 3 ES, 4 FS, 5 GS; an access with index 6 or 7 gives fault code 1, and a load with index 6 or 7 raises ld_fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0/3 real, 1 protected, 2 long |
| ld_valid | input | 1 | Selector/descriptor load request |
| ld_seg | input | 3 | Register index to load |
| ld_sel | input | 16 | Selector value |
| ld_base | input | 64 | Descriptor base |
| ld_limit | input | 32 | Descriptor limit (byte granular) |
| ld_code | input | 1 | Descriptor is a code segment |
| ld_long | input | 1 | Long-mode flag of a code descriptor |
| ld_fault | output | 1 | Load refused (general protection) |
| acc_valid | input | 1 | Memory reference request |
| acc_seg | input | 3 | Register index of the reference |
| acc_off | input | 64 | Effective offset |
| lin_addr | output | 64 | Linear address, zero when not valid |
| lin_valid | output | 1 | Translation valid |
| acc_fault | output | 2 | 0 none, 1 general protection, 2 stack fault |
| cpl | output | 2 | Current privilege level |
| eff_mode | output | 2 | 0 real, 1 32-bit, 2 64-bit |

## Verification
The bench targets the following corner cases:
- Real-mode wrap at selector 0xFFFF with offset 0xFFFF. A design that truncated to 20 bits would lose bit 20.
- 32-bit carry-out wrap. A design that kept the carry would report an address above 4 GiB.
- Offsets exactly at and one past the limit. An off-by-one comparison moves the fault edge.
- Stack-register limit faults. A design that missed this would report code 1 instead of code 2.
- 64-bit references through a register with a tiny limit and a nonzero base. These show whether the base is wrongly added or the limit wrongly applied, and FS and GS must still add their base.
- Refused loads, both null-code and wrong-type, followed by translations through the same register. These expose a design that overwrote the register anyway.

// File: rtl/seg_pkg.sv
package seg_pkg;

    parameter int ADDR_W = 64;
    parameter int SEL_W  = 16;
    parameter int LIM_W  = 32;
    parameter int NSEG   = 6;
    localparam int SEG_W = $clog2(NSEG + 1);

    localparam logic [SEG_W-1:0] SEG_CS = 3'd0;
    localparam logic [SEG_W-1:0] SEG_SS = 3'd1;
    localparam logic [SEG_W-1:0] SEG_DS = 3'd2;
    localparam logic [SEG_W-1:0] SEG_ES = 3'd3;
    localparam logic [SEG_W-1:0] SEG_FS = 3'd4;
    localparam logic [SEG_W-1:0] SEG_GS = 3'd5;

    localparam logic [1:0] MODE_PROT = 2'd1;
    localparam logic [1:0] MODE_LONG = 2'd2;

    typedef enum logic [1:0] {
        EFF_REAL = 2'd0,
        EFF_P32  = 2'd1,
        EFF_L64  = 2'd2
    } eff_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_STK  = 2'd2
    } fault_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              code;
        logic              lbit;
    } ld_desc_t;

    localparam logic [SEL_W-1:0]  RESET_CS_SEL  = 16'hF000;
    localparam logic [ADDR_W-1:0] RESET_CS_BASE = 64'h0000_0000_000F_0000;
    localparam logic [LIM_W-1:0]  RESET_LIMIT   = 32'h0000_FFFF;

    function automatic logic is_null(input logic [SEL_W-1:0] sel);
        return sel[SEL_W-1:2] == '0;
    endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prot_on,
    input  logic              ld_valid,
    input  logic [SEG_W-1:0]  ld_seg,
    input  logic [SEL_W-1:0]  ld_sel,
    input  ld_desc_t          ld_desc,
    output logic              ld_fault,
    output logic [SEL_W-1:0]  sel_q  [NSEG],
    output logic [ADDR_W-1:0] base_q [NSEG],
    output logic [LIM_W-1:0]  lim_q  [NSEG],
    output logic              cs_long
);

    logic bad;

    always_comb begin
        bad = 1'b0;
        if (ld_seg >= SEG_W'(NSEG)) begin
            bad = 1'b1;
        end else if (prot_on) begin
            if (ld_seg == SEG_CS)
                bad = is_null(ld_sel) || !ld_desc.code;
            else
                bad = !is_null(ld_sel) && ld_desc.code;
        end
    end

    assign ld_fault = ld_valid && bad;

    for (genvar g = 0; g < NSEG; g++) begin : g_reg
        logic wr;
        assign wr = ld_valid && !bad && (ld_seg == SEG_W'(g));

        if (g == 0) begin : g_code
            always_ff @(posedge clk) begin
                if (rst) begin
                    sel_q[g]  <= RESET_CS_SEL;
                    base_q[g] <= RESET_CS_BASE;
                    lim_q[g]  <= RESET_LIMIT;
                    cs_long   <= 1'b0;
                end else if (wr) begin
                    sel_q[g]  <= ld_sel;
                    base_q[g] <= ld_desc.base;
                    lim_q[g]  <= ld_desc.limit;
                    cs_long   <= ld_desc.lbit;
                end
            end
        end else begin : g_data
            always_ff @(posedge clk) begin
                if (rst) begin
                    sel_q[g]  <= '0;
                    base_q[g] <= '0;
                    lim_q[g]  <= RESET_LIMIT;
                end else if (wr) begin
                    sel_q[g]  <= ld_sel;
                    base_q[g] <= ld_desc.base;
                    lim_q[g]  <= ld_desc.limit;
                end
            end
        end

        AST_REFUSED_LOAD_KEEPS: assert property (@(posedge clk) disable iff (rst)
            (ld_fault && ld_seg == SEG_W'(g)) |=> ($stable(sel_q[g]) && $stable(base_q[g]))); // R8
    end

    AST_CS_NEVER_NULL: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !ld_fault && prot_on && ld_seg == SEG_CS) |=> !is_null(sel_q[0])); // R7

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  eff_e              eff,
    input  logic              acc_valid,
    input  logic [SEG_W-1:0]  acc_seg,
    input  logic [ADDR_W-1:0] acc_off,
    input  logic [SEL_W-1:0]  sel_q  [NSEG],
    input  logic [ADDR_W-1:0] base_q [NSEG],
    input  logic [LIM_W-1:0]  lim_q  [NSEG],
    output logic [ADDR_W-1:0] lin_addr,
    output logic              lin_valid,
    output fault_e            fault_o
);

    logic              seg_ok;
    logic [SEG_W-1:0]  sidx;
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  lim;
    logic [31:0]       real_sum;
    logic [31:0]       p32_sum;
    logic [ADDR_W-1:0] l64_base;
    logic [ADDR_W-1:0] sum;
    fault_e            flt;

    assign seg_ok = acc_seg < SEG_W'(NSEG);
    assign sidx   = seg_ok ? acc_seg : SEG_CS;
    assign sel    = sel_q[sidx];
    assign base   = base_q[sidx];
    assign lim    = lim_q[sidx];

    assign real_sum = 32'({sel, 4'b0000}) + {16'b0, acc_off[15:0]};
    assign p32_sum  = base[31:0] + acc_off[31:0];
    assign l64_base = (sidx == SEG_FS || sidx == SEG_GS) ? base : '0;

    always_comb begin
        flt = FLT_NONE;
        sum = '0;
        unique case (eff)
            EFF_L64: sum = l64_base + acc_off;
            EFF_P32: begin
                sum = ADDR_W'(p32_sum);
                if (sidx != SEG_CS && is_null(sel))
                    flt = FLT_GP;
                else if (acc_off[31:0] > 32'(lim))
                    flt = (sidx == SEG_SS) ? FLT_STK : FLT_GP;
            end
            default: sum = ADDR_W'(real_sum);
        endcase
        if (!seg_ok)
            flt = FLT_GP;
    end

    assign fault_o   = acc_valid ? flt : FLT_NONE;
    assign lin_valid = acc_valid && (flt == FLT_NONE);
    assign lin_addr  = lin_valid ? sum : '0;

    AST_REAL_SPAN: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && seg_ok && eff == EFF_REAL) |-> (lin_valid && lin_addr[ADDR_W-1:21] == '0)); // R2
    AST_P32_TRUNC: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && eff == EFF_P32) |-> (lin_addr[ADDR_W-1:32] == '0)); // R3
    AST_STK_ONLY_SS: assert property (@(posedge clk) disable iff (rst)
        (fault_o == FLT_STK) |-> (acc_seg == SEG_SS && eff == EFF_P32)); // R5
    AST_L64_FLAT: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && eff == EFF_L64 && acc_seg < SEG_FS) |-> (lin_valid && lin_addr == acc_off)); // R6
    AST_OOR_INDEX: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !seg_ok) |-> (fault_o == FLT_GP)); // R10

endmodule

// File: rtl/seg_translator.sv
module seg_translator
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              ld_valid,
    input  logic [SEG_W-1:0]  ld_seg,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [LIM_W-1:0]  ld_limit,
    input  logic              ld_code,
    input  logic              ld_long,
    output logic              ld_fault,
    input  logic              acc_valid,
    input  logic [SEG_W-1:0]  acc_seg,
    input  logic [ADDR_W-1:0] acc_off,
    output logic [ADDR_W-1:0] lin_addr,
    output logic              lin_valid,
    output logic [1:0]        acc_fault,
    output logic [1:0]        cpl,
    output logic [1:0]        eff_mode
);

    logic [SEL_W-1:0]  sel_q  [NSEG];
    logic [ADDR_W-1:0] base_q [NSEG];
    logic [LIM_W-1:0]  lim_q  [NSEG];
    logic              cs_long;
    logic              prot_on;
    ld_desc_t          ld_desc;
    eff_e              eff;
    fault_e            flt;

    assign prot_on = (mode == MODE_PROT) || (mode == MODE_LONG);
    assign ld_desc = '{base: ld_base, limit: ld_limit, code: ld_code, lbit: ld_long};

    always_comb begin
        if (mode == MODE_LONG)
            eff = cs_long ? EFF_L64 : EFF_P32;
        else if (mode == MODE_PROT)
            eff = EFF_P32;
        else
            eff = EFF_REAL;
    end

    seg_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .prot_on  (prot_on),
        .ld_valid (ld_valid),
        .ld_seg   (ld_seg),
        .ld_sel   (ld_sel),
        .ld_desc  (ld_desc),
        .ld_fault (ld_fault),
        .sel_q    (sel_q),
        .base_q   (base_q),
        .lim_q    (lim_q),
        .cs_long  (cs_long)
    );

    seg_xlate u_xlate (
        .clk       (clk),
        .rst       (rst),
        .eff       (eff),
        .acc_valid (acc_valid),
        .acc_seg   (acc_seg),
        .acc_off   (acc_off),
        .sel_q     (sel_q),
        .base_q    (base_q),
        .lim_q     (lim_q),
        .lin_addr  (lin_addr),
        .lin_valid (lin_valid),
        .fault_o   (flt)
    );

    assign acc_fault = flt;
    assign cpl       = sel_q[0][1:0];
    assign eff_mode  = eff;

    AST_RESET_REAL: assert property (@(posedge clk)
        $past(rst) |-> (cpl == 2'd0 && sel_q[0] == RESET_CS_SEL)); // R1
    AST_CPL_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !ld_fault && ld_seg == SEG_CS) |=> (cpl == $past(ld_sel[1:0]))); // R9

endmodule

// File: tb/sim_seg_translator.sv
module sim_seg_translator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic        ld_valid = 1'b0;
    logic [2:0]  ld_seg = '0;
    logic [15:0] ld_sel = '0;
    logic [63:0] ld_base = '0;
    logic [31:0] ld_limit = '0;
    logic        ld_code = 1'b0;
    logic        ld_long = 1'b0;
    logic        ld_fault;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_seg = '0;
    logic [63:0] acc_off = '0;
    logic [63:0] lin_addr;
    logic        lin_valid;
    logic [1:0]  acc_fault;
    logic [1:0]  cpl;
    logic [1:0]  eff_mode;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] lin;
        logic        v;
        logic [1:0]  f;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    seg_translator u0 (
        .clk(clk), .rst(rst), .mode(mode),
        .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel), .ld_base(ld_base),
        .ld_limit(ld_limit), .ld_code(ld_code), .ld_long(ld_long), .ld_fault(ld_fault),
        .acc_valid(acc_valid), .acc_seg(acc_seg), .acc_off(acc_off),
        .lin_addr(lin_addr), .lin_valid(lin_valid), .acc_fault(acc_fault),
        .cpl(cpl), .eff_mode(eff_mode)
    );

    // monitor: compares translation outputs against queued expectations
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            nchk++;
            if (lin_addr !== e.lin || lin_valid !== e.v || acc_fault !== e.f) begin
                nerr++;
                $display("FAIL %s: lin=%h v=%b f=%0d expected lin=%h v=%b f=%0d",
                         e.tag, lin_addr, lin_valid, acc_fault, e.lin, e.v, e.f);
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [2:0] seg, input logic [63:0] off,
                          input logic [63:0] elin, input logic ev, input logic [1:0] ef,
                          input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        acc_valid = 1'b1;
        acc_seg   = seg;
        acc_off   = off;
        e.lin = elin; e.v = ev; e.f = ef; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic load(input logic [2:0] seg, input logic [15:0] sel, input logic [63:0] base,
                        input logic [31:0] lim, input logic code, input logic lng,
                        input logic efault, input string tag);
        @(posedge clk);
        #1;
        ld_valid = 1'b1;
        ld_seg = seg; ld_sel = sel; ld_base = base; ld_limit = lim;
        ld_code = code; ld_long = lng;
        #2;
        check(tag, {63'b0, ld_fault}, {63'b0, efault});
        @(posedge clk);
        #1;
        ld_valid = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(posedge clk);
        #1;
        mode = m;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        #2;
        check("R1 cpl", {62'b0, cpl}, 64'd0);
        check("R1 eff_mode", {62'b0, eff_mode}, 64'd0);
        access(3'd0, 64'hFFF0, 64'h000F_FFF0, 1'b1, 2'd0, "R1 reset code fetch");

        // R2 real mode
        load(3'd2, 16'h1234, 64'h0, 32'h0, 1'b1, 1'b0, 1'b0, "R2 real load no fault");
        access(3'd2, 64'h0010, 64'h0001_2350, 1'b1, 2'd0, "R2 real sum");
        access(3'd2, 64'hFFFF_0000_0000_0010, 64'h0001_2350, 1'b1, 2'd0, "R2 upper offset ignored");
        load(3'd3, 16'hFFFF, 64'h0, 32'h0, 1'b0, 1'b0, 1'b0, "R2 real load ES");
        access(3'd3, 64'hFFFF, 64'h0010_FFEF, 1'b1, 2'd0, "R2 real wrap above 1MiB");

        // R3 protected
        set_mode(2'd1);
        load(3'd0, 16'h0008, 64'h1000_0000, 32'h000F_FFFF, 1'b1, 1'b0, 1'b0, "R3 CS load");
        access(3'd0, 64'h100, 64'h1000_0100, 1'b1, 2'd0, "R3 CS base+off");
        load(3'd2, 16'h0010, 64'hFFFF_F000, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R3 DS load");
        access(3'd2, 64'h2000, 64'h0000_1000, 1'b1, 2'd0, "R3 32-bit wrap");
        access(3'd2, 64'hABCD_0000_0000_2000, 64'h0000_1000, 1'b1, 2'd0, "R3 upper offset ignored");

        // R4 limit
        load(3'd3, 16'h0018, 64'h2000, 32'h0000_00FF, 1'b0, 1'b0, 1'b0, "R4 ES load");
        access(3'd3, 64'hFF, 64'h20FF, 1'b1, 2'd0, "R4 at limit");
        access(3'd3, 64'h100, 64'h0, 1'b0, 2'd1, "R4 past limit GP");

        // R5 stack fault
        load(3'd1, 16'h0023, 64'h3000, 32'h0000_000F, 1'b0, 1'b0, 1'b0, "R5 SS load");
        access(3'd1, 64'h10, 64'h0, 1'b0, 2'd2, "R5 SS limit stack fault");
        access(3'd1, 64'h0F, 64'h300F, 1'b1, 2'd0, "R5 SS at limit");

        // R7 null selectors
        load(3'd0, 16'h0003, 64'h0, 32'hFFFF, 1'b1, 1'b0, 1'b1, "R7 null CS refused");
        access(3'd0, 64'h100, 64'h1000_0100, 1'b1, 2'd0, "R7 CS unchanged after refusal");
        check("R9 cpl kept", {62'b0, cpl}, 64'd0);
        load(3'd4, 16'h0000, 64'h7000, 32'hFFFF, 1'b0, 1'b0, 1'b0, "R7 null FS accepted");
        access(3'd4, 64'h0, 64'h0, 1'b0, 2'd1, "R7 null FS ref GP in 32-bit");

        // R8 type checks
        load(3'd2, 16'h0028, 64'h9000, 32'hFFFF, 1'b1, 1'b0, 1'b1, "R8 code into DS refused");
        access(3'd2, 64'h2000, 64'h0000_1000, 1'b1, 2'd0, "R8 DS unchanged");
        load(3'd0, 16'h0030, 64'h9000, 32'hFFFF, 1'b0, 1'b0, 1'b1, "R8 data into CS refused");

        // R10 index range
        access(3'd6, 64'h0, 64'h0, 1'b0, 2'd1, "R10 access index 6");
        load(3'd7, 16'h0010, 64'h0, 32'h0, 1'b0, 1'b0, 1'b1, "R10 load index 7");

        // R9 compatibility in long mode
        set_mode(2'd2);
        #2;
        check("R9 compat eff_mode", {62'b0, eff_mode}, 64'd1);
        access(3'd3, 64'h100, 64'h0, 1'b0, 2'd1, "R9 compat keeps limit check");

        // R6 64-bit operation
        load(3'd0, 16'h0033, 64'h5555_0000, 32'h0, 1'b1, 1'b1, 1'b0, "R6 long CS load");
        #2;
        check("R9 long eff_mode", {62'b0, eff_mode}, 64'd2);
        check("R9 cpl 3", {62'b0, cpl}, 64'd3);
        access(3'd0, 64'h0000_1234_5678_9ABC, 64'h0000_1234_5678_9ABC, 1'b1, 2'd0, "R6 CS base zero");
        access(3'd3, 64'h100, 64'h100, 1'b1, 2'd0, "R6 ES no limit no base");
        access(3'd1, 64'h1000, 64'h1000, 1'b1, 2'd0, "R6 SS no stack fault");
        load(3'd5, 16'h003B, 64'hFFFF_8000_0000_0000, 32'h0, 1'b0, 1'b0, 1'b0, "R6 GS load");
        access(3'd5, 64'h10, 64'hFFFF_8000_0000_0010, 1'b1, 2'd0, "R6 GS base added");
        access(3'd4, 64'h5, 64'h7005, 1'b1, 2'd0, "R7 null FS ok in 64-bit");

        @(posedge clk);
        #1 acc_valid = 1'b0;
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule